// File: doc/BRIEF.md
# Two-wire memory slave engine

This block is the bus-facing half of a 256-byte serial memory. It watches the two bus wires (clock and data), which it samples with the system clock, and finds the start and stop conditions. It shifts bytes in and out, and it pulls the data wire low only through an active-low open-drain enable. The first byte after a start is a control byte. That byte selects either the memory array or a one-time protect register, and only a device whose chip-select pins match the byte answers.

For writes, the engine loads an address pointer and then passes each data byte toward a downstream page buffer as a one-cycle request. It flags the end of the transaction with a commit pulse. For reads, it fetches bytes from an asynchronous read port at the pointer and steps the pointer after each byte. An external write-cycle timer reports when it is busy. While it is busy, the engine answers nothing, so a master can poll with acknowledges. An arbiter reports whether the protect register has already been set.

Top module: `twowire_mem_slave`

## Requirements
- R1: A start is the data wire falling while the clock wire is high, and a stop is the data wire rising while the clock wire is high. Data-wire changes while the clock is low are data bits, taken MSB first on each clock rise. A stop returns the engine to idle.
- R2: The control byte holds a 4-bit code in bits 7..4, a chip select in bits 3..1 that must equal `sel_i`, and a direction bit in bit 0, where 1 means read. Code 1010 with a matching select is acknowledged for both directions.
- R3: A control byte with a code other than 1010 or 0110, or with a chip select that does not match, is not acknowledged. The engine then stays silent on every byte until the next start.
- R4: Code 0110 with the write direction is acknowledged while `prot_set_i` is 0. Its address byte and data bytes are acknowledged, and the address byte leaves the pointer unchanged. Each data byte gives a request with `wr_prot`=1. Code 0110 with the read direction, or any 0110 byte while `prot_set_i` is 1, is not acknowledged.
- R5: While `busy_i` is 1, no byte is acknowledged, including the control byte.
- R6: In a write, the byte after the control byte loads the pointer. Each later byte raises `wr_req` for one cycle, with `wr_addr` set to the pointer and `wr_data` set to the byte. After each data byte the pointer's low 4 bits step and wrap inside a 16-byte page, while the high 4 bits stay fixed.
- R7: A stop that ends a write after at least one data byte gives one single-cycle `wr_commit`. A stop or a repeated start after only the address byte gives no commit and keeps the loaded pointer.
- R8: A read sends the byte at the pointer MSB first and then increments the pointer, wrapping from FFh to 00h. A master acknowledge (data low on the ninth clock) sends the next byte.
- R9: A master non-acknowledge ends the read. The engine releases the data wire and drives nothing until the next start.
- R10: The engine acknowledges by holding the data wire low through the high phase of the ninth clock, and it releases the wire after that clock falls.
- R11: A start at any point, including in the middle of a byte, drops the partial byte and restarts control-byte reception.
- R12: After reset the data wire is released, `wr_req` and `wr_commit` are 0, and the pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock wire level |
| sda_i | input | 1 | Bus data wire level |
| sel_i | input | 3 | Chip-select strap compared with control bits 3..1 |
| sda_oe_n | output | 1 | Active-low enable that pulls the data wire low |
| rd_addr | output | 8 | Read-port address (the pointer) |
| rd_data | input | 8 | Read-port data, valid in the same cycle as the address |
| wr_req | output | 1 | One-cycle pulse per received data byte |
| wr_addr | output | 8 | Target address of the request |
| wr_data | output | 8 | Data byte of the request |
| wr_prot | output | 1 | Request targets the protect register |
| wr_commit | output | 1 | One-cycle pulse that starts the write cycle |
| busy_i | input | 1 | Write-cycle timer busy |
| prot_set_i | input | 1 | Protect register already set |

## Verification
The assertions assume that the bus clock and data wires move slowly compared with the system clock. They also assume that the master never makes a start or stop while the engine pulls the data wire low, and that `busy_i` stays still during the clock-fall cycle at which an acknowledge is decided. The stimulus keeps to these by using a bit time of twenty system clocks. The master changes data only five cycles after a clock fall, releases its line on every acknowledge the engine owns, and changes `busy_i` only between transactions.

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave #(
  parameter int AW = 8,
  parameter int PW = 4,
  parameter logic [3:0] ARR_CODE = 4'b1010,
  parameter logic [3:0] PROT_CODE = 4'b0110
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    sel_i,
  output logic          sda_oe_n,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          wr_prot,
  output logic          wr_commit,
  input  logic          busy_i,
  input  logic          prot_set_i
);
  localparam logic [2:0] S_IDLE = 3'd0, S_CTRL = 3'd1, S_ADDR = 3'd2,
                         S_WDAT = 3'd3, S_RD = 3'd4;

  logic [1:0] scl_m, sda_m;
  logic scl_q, sda_q;
  logic [2:0] st;
  logic [3:0] cnt;
  logic [7:0] sh, tx;
  logic [AW-1:0] ptr;
  logic drv, prot_q, have_data;

  wire scl_s = scl_m[1];
  wire sda_s = sda_m[1];
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire rise = scl_s & ~scl_q;
  wire fall = ~scl_s & scl_q;
  wire rd_phase = (st == S_RD);

  wire cs_ok = (sh[3:1] == sel_i);
  wire ctrl_ack = ~busy_i & cs_ok &
                  ((sh[7:4] == ARR_CODE) | ((sh[7:4] == PROT_CODE) & ~sh[0] & ~prot_set_i));
  wire byte_ack = (st == S_CTRL) ? ctrl_ack : ~busy_i;
  wire [AW-1:0] page_next = {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};

  assign sda_oe_n = ~drv;
  assign rd_addr  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 2'b11; sda_m <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
      st <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0; ptr <= '0;
      drv <= 1'b0; prot_q <= 1'b0; have_data <= 1'b0;
      wr_req <= 1'b0; wr_addr <= '0; wr_data <= '0; wr_prot <= 1'b0; wr_commit <= 1'b0;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
      wr_req <= 1'b0;
      wr_commit <= 1'b0;
      if (start_det) begin
        st <= S_CTRL; cnt <= '0; drv <= 1'b0; have_data <= 1'b0;
      end else if (stop_det) begin
        if (st == S_WDAT && have_data) wr_commit <= 1'b1;
        st <= S_IDLE; drv <= 1'b0; have_data <= 1'b0;
      end else begin
        case (st)
          S_CTRL, S_ADDR, S_WDAT: begin
            if (rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (fall && cnt == 4'd8) begin
              if (byte_ack) begin
                drv <= 1'b1;
                cnt <= 4'd9;
                if (st == S_CTRL) prot_q <= (sh[7:4] == PROT_CODE);
                if (st == S_ADDR && !prot_q) ptr <= sh[AW-1:0];
                if (st == S_WDAT) begin
                  wr_req <= 1'b1; wr_addr <= ptr; wr_data <= sh; wr_prot <= prot_q;
                  have_data <= 1'b1;
                  if (!prot_q) ptr <= page_next;
                end
              end else begin
                st <= S_IDLE;
              end
            end else if (fall && cnt == 4'd9) begin
              cnt <= '0;
              if (st == S_CTRL && sh[0]) begin
                st <= S_RD; tx <= rd_data; drv <= ~rd_data[7]; ptr <= ptr + 1'b1;
              end else begin
                drv <= 1'b0;
                if (st == S_CTRL) st <= S_ADDR;
                else if (st == S_ADDR) st <= S_WDAT;
              end
            end
          end
          S_RD: begin
            if (rise) begin
              if (cnt < 4'd8) cnt <= cnt + 1'b1;
              else if (cnt == 4'd8) begin
                if (sda_s) st <= S_IDLE;
                else cnt <= 4'd9;
              end
            end else if (fall) begin
              if (cnt >= 4'd1 && cnt <= 4'd7) begin
                tx <= {tx[6:0], 1'b0}; drv <= ~tx[6];
              end else if (cnt == 4'd8) begin
                drv <= 1'b0;
              end else if (cnt == 4'd9) begin
                cnt <= '0; tx <= rd_data; drv <= ~rd_data[7]; ptr <= ptr + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twowire_mem_slave_props.sv
module twowire_mem_slave_props (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic scl_q,
  input logic start_det,
  input logic sda_oe_n,
  input logic busy_i,
  input logic rd_phase,
  input logic wr_req,
  input logic wr_commit
);
  logic seen_req;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_req <= 1'b0;
    else if (start_det) seen_req <= 1'b0;
    else if (wr_req) seen_req <= 1'b1;
  end

  p_no_edge_scl_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q) |=> $stable(sda_oe_n));

  p_silent_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe_n) && !$past(rd_phase)) |-> !$past(busy_i));

  p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);

  p_commit_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

  p_commit_after_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> seen_req);
endmodule

bind twowire_mem_slave twowire_mem_slave_props u_props (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_q(scl_q), .start_det(start_det),
  .sda_oe_n(sda_oe_n), .busy_i(busy_i), .rd_phase(rd_phase),
  .wr_req(wr_req), .wr_commit(wr_commit)
);

// File: tb/sim_twowire_mem_slave.sv
module sim_twowire_mem_slave;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] CW = 8'hAA, CR = 8'hAB, PWR = 8'h6A, PRD = 8'h6B;
  localparam logic [7:0] BAD_CS = 8'hA6, BAD_CODE = 8'hBA;
  localparam logic [15:0] VEC [6] = '{16'h10C3, 16'h7F00, 16'h80FF, 16'hFF5A, 16'h0081, 16'h453C};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1;
  logic busy = 1'b0, prot_set = 1'b0;
  logic sda_oe_n, wr_req, wr_prot, wr_commit;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
  wire sda_line = m_sda & sda_oe_n;

  logic [7:0] mem [256];
  logic [7:0] log_addr [16];
  logic [7:0] log_data [16];
  logic last_prot;
  int nreq = 0, ncommit = 0, tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  twowire_mem_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sel_i(SEL),
    .sda_oe_n(sda_oe_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_prot(wr_prot),
    .wr_commit(wr_commit), .busy_i(busy), .prot_set_i(prot_set)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'(i) ^ 8'hA5;
  endfunction

  assign rd_data = mem[rd_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = pat(i);
    end else begin
      if (wr_req) begin
        log_addr[nreq % 16] = wr_addr;
        log_data[nreq % 16] = wr_data;
        last_prot = wr_prot;
        nreq++;
        if (!wr_prot) mem[wr_addr] = wr_data;
      end
      if (wr_commit) ncommit++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clock_bit(input logic mb, output logic sb);
    m_sda = mb; tick(5);
    scl = 1'b1; tick(5);
    sb = sda_line; tick(5);
    scl = 1'b0; tick(5);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(5);
    scl = 1'b1; tick(5);
    m_sda = 1'b0; tick(5);
    scl = 1'b0; tick(5);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(5);
    scl = 1'b1; tick(5);
    m_sda = 1'b1; tick(5);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, s);
      d = {d[6:0], s};
    end
    clock_bit(~mack, s);
  endtask

  task automatic set_ptr(input logic [7:0] a);
    logic k;
    bus_start(); send_byte(CW, k); send_byte(a, k); bus_start();
  endtask

  initial begin
    logic ack;
    logic [7:0] d, a;
    logic s;
    int r0, c0;
    tick(6);
    chk("R12 sda released in reset", sda_oe_n, 1);
    rst_n = 1'b1; tick(3);
    chk("R12 sda released after reset", sda_oe_n, 1);
    chk("R12 no request after reset", wr_req, 0);
    chk("R12 no commit after reset", wr_commit, 0);

    bus_start(); send_byte(CR, ack);
    chk("R2 read control acked", ack, 1);
    recv_byte(1'b0, d); bus_stop();
    chk("R12 pointer zero after reset", d, pat(0));

    for (int v = 0; v < 6; v++) begin
      a = VEC[v][15:8];
      r0 = nreq; c0 = ncommit;
      bus_start(); send_byte(CW, ack);
      chk("R2 write control acked", ack, 1);
      send_byte(a, ack);
      chk("R6 address acked", ack, 1);
      send_byte(VEC[v][7:0], ack);
      chk("R10 data acked", ack, 1);
      bus_stop(); tick(4);
      chk("R6 one request", nreq, r0 + 1);
      chk("R6 request address", log_addr[r0 % 16], a);
      chk("R6 request data", log_data[r0 % 16], VEC[v][7:0]);
      chk("R7 commit on stop", ncommit, c0 + 1);
      set_ptr(a); send_byte(CR, ack);
      recv_byte(1'b0, d); bus_stop(); tick(4);
      chk("R8 random read data", d, VEC[v][7:0]);
      chk("R7 no commit on repeated start", ncommit, c0 + 1);
    end

    r0 = nreq; c0 = ncommit;
    bus_start(); send_byte(CW, ack); send_byte(8'h3E, ack);
    send_byte(8'h11, ack); send_byte(8'h22, ack); send_byte(8'h33, ack);
    bus_stop(); tick(4);
    chk("R6 page byte 0 address", log_addr[r0 % 16], 8'h3E);
    chk("R6 page byte 1 address", log_addr[(r0 + 1) % 16], 8'h3F);
    chk("R6 page wrap address", log_addr[(r0 + 2) % 16], 8'h30);
    chk("R6 page wrap data", log_data[(r0 + 2) % 16], 8'h33);
    chk("R7 single commit for page", ncommit, c0 + 1);

    set_ptr(8'hFE); send_byte(CR, ack);
    recv_byte(1'b1, d); chk("R8 sequential first", d, pat(8'hFE));
    recv_byte(1'b1, d); chk("R8 sequential second", d, 8'h5A);
    recv_byte(1'b0, d); chk("R8 pointer wrap to 00", d, 8'h81);
    bus_stop();
    bus_start(); send_byte(CR, ack); recv_byte(1'b0, d);
    chk("R8 current address after wrap", d, pat(1));
    for (int i = 0; i < 9; i++) begin
      clock_bit(1'b1, s);
      chk("R9 released after nack", s, 1);
    end
    bus_stop();

    r0 = nreq;
    bus_start(); send_byte(BAD_CS, ack);
    chk("R3 wrong chip select not acked", ack, 0);
    send_byte(8'h00, ack);
    chk("R3 silent after reject", ack, 0);
    bus_stop();
    bus_start(); send_byte(BAD_CODE, ack);
    chk("R3 wrong code not acked", ack, 0);
    bus_stop(); tick(4);
    chk("R3 no request from rejected", nreq, r0);

    busy = 1'b1;
    bus_start(); send_byte(CW, ack);
    chk("R5 control not acked while busy", ack, 0);
    bus_stop();
    busy = 1'b0;
    c0 = ncommit;
    bus_start(); send_byte(CW, ack);
    chk("R5 acked once idle", ack, 1);
    bus_stop(); tick(4);
    chk("R7 no commit without data", ncommit, c0);

    set_ptr(8'h20); send_byte(CR, ack); recv_byte(1'b0, d); bus_stop();
    bus_start(); send_byte(PRD, ack);
    chk("R4 protect read not acked", ack, 0);
    bus_stop();
    r0 = nreq; c0 = ncommit;
    bus_start(); send_byte(PWR, ack);
    chk("R4 protect write acked", ack, 1);
    send_byte(8'h77, ack);
    chk("R4 protect address acked", ack, 1);
    send_byte(8'h99, ack);
    chk("R4 protect data acked", ack, 1);
    bus_stop(); tick(4);
    chk("R4 protect request flagged", {31'd0, last_prot}, 1);
    chk("R4 protect request count", nreq, r0 + 1);
    chk("R7 protect commit", ncommit, c0 + 1);
    bus_start(); send_byte(CR, ack); recv_byte(1'b0, d); bus_stop();
    chk("R4 pointer untouched by protect address", d, pat(8'h21));
    prot_set = 1'b1;
    bus_start(); send_byte(PWR, ack);
    chk("R4 protect write refused once set", ack, 0);
    bus_stop();
    prot_set = 1'b0;

    c0 = ncommit;
    bus_start();
    for (int i = 0; i < 4; i++) clock_bit(CW[7 - i], s);
    bus_start(); send_byte(CW, ack);
    chk("R11 control acked after abort", ack, 1);
    send_byte(8'h50, ack);
    chk("R10 address acked", ack, 1);
    chk("R10 released after ninth clock", sda_line, 1);
    bus_stop(); tick(4);
    chk("R7 stop after address no commit", ncommit, c0);
    bus_start(); send_byte(CR, ack); recv_byte(1'b0, d); bus_stop();
    chk("R1 pointer kept across stop", d, pat(8'h50));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule